// File: doc/BRIEF.md
# Dual-Core Boot-Hold Power Sequencer

This block sequences the run, sleep and stop states of a primary and a secondary processor that share one system power domain. After reset the primary core runs. The secondary core is kept in a boot-hold state until software on the primary core sets a boot-enable flag. A separate status output tells software whether the secondary core has actually been released. An access aimed at the secondary core while it is still held sets a sticky illegal-access flag, which a write-one-to-clear pulse removes.

The secondary core can produce a wakeup while the boot flag is clear. That wakeup is sent to the primary core instead, so the primary core can bring the system up and set the flag. The wakeup is also latched as pending, so that the secondary core starts on its own once the flag is set. Once every core has stopped and that condition has held for `STOP_SETTLE` cycles, the block moves the system into Stop, or into Standby when a standby request is present. Any wakeup brings the system back to Run on the same edge that restarts the core.

Per-core states are RUN, SLEEP, STOP and HOLD. HOLD is used only by the secondary core. The transitions are:

- RUN to STOP on a stop request. The primary core takes this transition only while the boot flag is clear.
- RUN to SLEEP on a sleep request. A stop request takes priority over a sleep request.
- SLEEP to RUN and STOP to RUN on a wakeup.
- Secondary STOP to HOLD when the boot flag reads 0.
- HOLD to RUN when the boot flag reads 1, provided either the secondary core has never booted or a wakeup is pending for it.

System states are SYS_RUN, SYS_SETTLE, SYS_STOP and SYS_STBY. The transitions are:

- SYS_RUN to SYS_SETTLE once all cores are stopped.
- SYS_SETTLE back to SYS_RUN on a wakeup or when any core leaves stop.
- SYS_SETTLE to SYS_STOP or SYS_STBY when the settle count expires. The standby request chooses between them.
- SYS_STOP or SYS_STBY to SYS_RUN on any wakeup.

Top module: `dual_core_boot_seq`

## Requirements
- R1: After reset the primary core runs (`p_clk_en`=1, `p_run_en`=1). The secondary core is held (`s_clk_en`=0, `s_run_en`=0). `sys_mode`=00, and `boot_flag`, `boot_status` and `illegal` are all 0.
- R2: The secondary core leaves hold one edge after `boot_flag` reads 1, and `boot_status` goes to 1 at that edge. A later release from hold also requires a pending secondary wakeup. Without one, the core stays held even when the flag is 1.
- R3: A primary stop request is ignored while `boot_flag` is 1.
- R4: When a stopped secondary core sees `boot_flag` at 0, it returns to hold on the next edge and `boot_status` drops to 0.
- R5: A `s_wake` pulse while `boot_flag` is 0 wakes the primary core and the system on that edge. The wakeup is latched as pending so that the secondary core is released once the flag is set.
- R6: Each core's enables follow its state. RUN gives clock 1 and run 1. SLEEP gives clock 0 and run 1. STOP and HOLD give 0 and 0. A core in SLEEP returns to RUN on its wakeup.
- R7: `sys_mode` uses the code 00 for Run, 01 for Stop and 10 for Standby. When all cores are stopped, the mode stays 00 for `STOP_SETTLE`+1 edges after the stop edge, then changes to 10 if `stby_req` is 1 and to 01 otherwise.
- R8: A wakeup in Stop or Standby returns `sys_mode` to 00 on the same edge that the woken core returns to RUN.
- R9: `illegal` is set by `s_access` while `boot_status` is 0. It stays set until an `ill_clr` pulse clears it. If an access and a clear arrive in the same cycle, the set wins. An access while `boot_status` is 1 has no effect.
- R10: `boot_flag` follows `boot_set` and `boot_clr` pulses one edge later. If both arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p_sleep_req | input | 1 | Primary core sleep request pulse |
| p_stop_req | input | 1 | Primary core stop request pulse |
| p_wake | input | 1 | Primary core wakeup event |
| s_sleep_req | input | 1 | Secondary core sleep request pulse |
| s_stop_req | input | 1 | Secondary core stop request pulse |
| s_wake | input | 1 | Secondary core wakeup event |
| boot_set | input | 1 | Write 1 to the boot-enable flag |
| boot_clr | input | 1 | Write 0 to the boot-enable flag |
| stby_req | input | 1 | Standby request level |
| s_access | input | 1 | Access attempt aimed at the secondary core |
| ill_clr | input | 1 | Write-one-to-clear pulse for the illegal flag |
| p_clk_en | output | 1 | Primary core clock enable |
| p_run_en | output | 1 | Primary core run (not stopped) enable |
| s_clk_en | output | 1 | Secondary core clock enable |
| s_run_en | output | 1 | Secondary core run (not stopped) enable |
| sys_mode | output | 2 | System mode: 00 Run, 01 Stop, 10 Standby |
| boot_flag | output | 1 | Boot-enable flag |
| boot_status | output | 1 | Secondary core released from hold |
| illegal | output | 1 | Sticky illegal-access flag |

## Verification
The bench builds the block with `STOP_SETTLE` = 3 instead of the default 8. This keeps each entry into Stop or Standby within a few cycles, so the vector table can step through several full stop, standby and wake rounds. It also lets the settle boundary be checked on the exact edge before and the exact edge after the mode changes. The short settle window allows the redirected-wakeup sequence to run from end to end. That sequence is: secondary wake while held, primary restart, flag set with the pending wake, flag clear and a return to Standby.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] MODE_RUN  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_STOP = 2'b01;
    localparam logic [MODE_W-1:0] MODE_STBY = 2'b10;

    typedef enum logic [1:0] {
        CORE_RUN   = 2'd0,
        CORE_SLEEP = 2'd1,
        CORE_STOP  = 2'd2,
        CORE_HOLD  = 2'd3
    } core_st_e;

    typedef enum logic [1:0] {
        SYS_RUN    = 2'd0,
        SYS_SETTLE = 2'd1,
        SYS_STOP   = 2'd2,
        SYS_STBY   = 2'd3
    } sys_st_e;

endpackage

// File: rtl/dcb_boot_ctrl.sv
module dcb_boot_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_set,
    input  logic boot_clr,
    input  logic s_access,
    input  logic ill_clr,
    input  logic s_wake,
    input  logic sec_hold,
    output logic boot_flag,
    output logic illegal,
    output logic wake_pend
);

    logic flag_q;
    logic ill_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (boot_set) begin
            flag_q <= 1'b1;
        end else if (boot_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ill_q <= 1'b0;
        end else if (s_access && sec_hold) begin
            ill_q <= 1'b1;
        end else if (ill_clr) begin
            ill_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (s_wake && sec_hold) begin
            pend_q <= 1'b1;
        end else if (!sec_hold) begin
            pend_q <= 1'b0;
        end
    end

    assign boot_flag = flag_q;
    assign illegal   = ill_q;
    assign wake_pend = pend_q;

    // R9
    ill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_access && sec_hold) |=> illegal);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_set |=> boot_flag);

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wake && sec_hold) |=> wake_pend);

endmodule

// File: rtl/dcb_core_fsm.sv
module dcb_core_fsm
    import dcb_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_req,
    input  logic     stop_req,
    input  logic     wake,
    input  logic     boot_flag,
    input  logic     wake_pend,
    output core_st_e state,
    output logic     clk_en,
    output logic     run_en
);

    localparam core_st_e RESET_ST = SECONDARY ? CORE_HOLD : CORE_RUN;

    core_st_e state_q;
    core_st_e state_d;
    logic     booted_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_RUN: begin
                if (stop_req && (SECONDARY || !boot_flag)) begin
                    state_d = CORE_STOP;
                end else if (sleep_req) begin
                    state_d = CORE_SLEEP;
                end
            end
            CORE_SLEEP: begin
                if (wake) begin
                    state_d = CORE_RUN;
                end
            end
            CORE_STOP: begin
                if (SECONDARY && !boot_flag) begin
                    state_d = CORE_HOLD;
                end else if (wake) begin
                    state_d = CORE_RUN;
                end
            end
            CORE_HOLD: begin
                if (!SECONDARY) begin
                    state_d = CORE_RUN;
                end else if (boot_flag && (!booted_q || wake_pend)) begin
                    state_d = CORE_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RESET_ST;
            booted_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CORE_HOLD && state_d == CORE_RUN) begin
                booted_q <= 1'b1;
            end
        end
    end

    always_comb begin
        clk_en = 1'b0;
        run_en = 1'b0;
        unique case (state_q)
            CORE_RUN: begin
                clk_en = 1'b1;
                run_en = 1'b1;
            end
            CORE_SLEEP: begin
                run_en = 1'b1;
            end
            CORE_STOP, CORE_HOLD: begin
                clk_en = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R3
    prim_stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!SECONDARY && state_q == CORE_RUN && boot_flag) |=> (state_q != CORE_STOP));

    // R4
    hold_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SECONDARY && state_q == CORE_STOP && !boot_flag) |=> (state_q == CORE_HOLD));

    // R2
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SECONDARY && state_q == CORE_HOLD && !boot_flag) |=> (state_q == CORE_HOLD));

endmodule

// File: rtl/dcb_sys_mode.sv
module dcb_sys_mode
    import dcb_pkg::*;
#(
    parameter int STOP_SETTLE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  core_st_e          p_state,
    input  core_st_e          s_state,
    input  logic              any_wake,
    input  logic              stby_req,
    output logic [MODE_W-1:0] sys_mode
);

    localparam int CNT_W = $clog2(STOP_SETTLE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STOP_SETTLE - 1);

    sys_st_e          state_q;
    sys_st_e          state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             all_stop;

    assign all_stop = (p_state == CORE_STOP) &&
                      ((s_state == CORE_STOP) || (s_state == CORE_HOLD));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SYS_RUN: begin
                if (all_stop && !any_wake) begin
                    state_d = SYS_SETTLE;
                    cnt_d   = '0;
                end
            end
            SYS_SETTLE: begin
                if (any_wake || !all_stop) begin
                    state_d = SYS_RUN;
                end else if (cnt_q == LAST) begin
                    state_d = stby_req ? SYS_STBY : SYS_STOP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SYS_STOP, SYS_STBY: begin
                if (any_wake || !all_stop) begin
                    state_d = SYS_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SYS_STOP: sys_mode = MODE_STOP;
            SYS_STBY: sys_mode = MODE_STBY;
            SYS_RUN, SYS_SETTLE: sys_mode = MODE_RUN;
        endcase
    end

    // R7
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SYS_SETTLE && cnt_q == LAST && all_stop && !any_wake)
            |=> (sys_mode != MODE_RUN));

    // R8
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wake && (state_q == SYS_STOP || state_q == SYS_STBY))
            |=> (sys_mode == MODE_RUN));

endmodule

// File: rtl/dual_core_boot_seq.sv
module dual_core_boot_seq
    import dcb_pkg::*;
#(
    parameter int STOP_SETTLE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_sleep_req,
    input  logic              p_stop_req,
    input  logic              p_wake,
    input  logic              s_sleep_req,
    input  logic              s_stop_req,
    input  logic              s_wake,
    input  logic              boot_set,
    input  logic              boot_clr,
    input  logic              stby_req,
    input  logic              s_access,
    input  logic              ill_clr,
    output logic              p_clk_en,
    output logic              p_run_en,
    output logic              s_clk_en,
    output logic              s_run_en,
    output logic [MODE_W-1:0] sys_mode,
    output logic              boot_flag,
    output logic              boot_status,
    output logic              illegal
);

    core_st_e p_state;
    core_st_e s_state;
    logic     wake_pend;
    logic     p_wake_eff;
    logic     sec_hold;

    assign sec_hold    = (s_state == CORE_HOLD);
    assign p_wake_eff  = p_wake | (s_wake & ~boot_flag);
    assign boot_status = ~sec_hold;

    dcb_boot_ctrl u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_set  (boot_set),
        .boot_clr  (boot_clr),
        .s_access  (s_access),
        .ill_clr   (ill_clr),
        .s_wake    (s_wake),
        .sec_hold  (sec_hold),
        .boot_flag (boot_flag),
        .illegal   (illegal),
        .wake_pend (wake_pend)
    );

    dcb_core_fsm #(.SECONDARY(1'b0)) u_core_p (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (p_sleep_req),
        .stop_req  (p_stop_req),
        .wake      (p_wake_eff),
        .boot_flag (boot_flag),
        .wake_pend (1'b0),
        .state     (p_state),
        .clk_en    (p_clk_en),
        .run_en    (p_run_en)
    );

    dcb_core_fsm #(.SECONDARY(1'b1)) u_core_s (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (s_sleep_req),
        .stop_req  (s_stop_req),
        .wake      (s_wake),
        .boot_flag (boot_flag),
        .wake_pend (wake_pend),
        .state     (s_state),
        .clk_en    (s_clk_en),
        .run_en    (s_run_en)
    );

    dcb_sys_mode #(.STOP_SETTLE(STOP_SETTLE)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .p_state  (p_state),
        .s_state  (s_state),
        .any_wake (p_wake | s_wake),
        .stby_req (stby_req),
        .sys_mode (sys_mode)
    );

    // R5
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wake && !boot_flag && !p_run_en) |=> p_clk_en);

endmodule

// File: tb/dual_core_boot_seq_tb.sv
module dual_core_boot_seq_tb;

    localparam int SETTLE = 3;
    localparam int NVEC   = 20;

    // stimulus bits: p_sleep p_stop s_sleep s_stop p_wake s_wake boot_set boot_clr stby s_access ill_clr
    // expected bits: p_clk p_run s_clk s_run mode[1:0] flag status illegal
    localparam logic [23:0] VEC [NVEC] = '{
        {11'b00000000010, 4'd0, 9'b1100_00_001}, // R9 access while held
        {11'b00000000001, 4'd0, 9'b1100_00_000}, // R9 clear
        {11'b00000100000, 4'd0, 9'b1100_00_000}, // R5 wake while held, primary already running
        {11'b00000010000, 4'd1, 9'b1111_00_110}, // R2 R10 first release in Run
        {11'b00000000010, 4'd0, 9'b1111_00_110}, // R9 access while released ignored
        {11'b01000000000, 4'd0, 9'b1111_00_110}, // R3 primary stop ignored
        {11'b00100000000, 4'd0, 9'b1101_00_110}, // R6 secondary sleep
        {11'b00000100000, 4'd0, 9'b1111_00_110}, // R6 secondary wake from sleep
        {11'b00010000000, 4'd0, 9'b1100_00_110}, // R6 secondary stop
        {11'b00000001000, 4'd1, 9'b1100_00_000}, // R4 flag clear returns to hold
        {11'b10000000000, 4'd0, 9'b0100_00_000}, // R6 primary sleep
        {11'b00001000000, 4'd0, 9'b1100_00_000}, // R6 primary wake
        {11'b01000000000, 4'd4, 9'b0000_01_000}, // R7 system stop
        {11'b00000100000, 4'd0, 9'b1100_00_000}, // R5 R8 redirected wake
        {11'b00000010000, 4'd1, 9'b1111_00_110}, // R5 R2 pending release
        {11'b00000001000, 4'd0, 9'b1111_00_010}, // R10 flag clear
        {11'b01000000000, 4'd0, 9'b0011_00_010}, // R3 primary stop accepted
        {11'b00010000000, 4'd1, 9'b0000_00_000}, // R4 R7 settling
        {11'b00000000100, 4'd2, 9'b0000_10_000}, // R7 standby
        {11'b00001000000, 4'd0, 9'b1100_00_000}  // R8 wake from standby
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [10:0] stim = '0;
    logic       p_clk_en, p_run_en, s_clk_en, s_run_en;
    logic [1:0] sys_mode;
    logic       boot_flag, boot_status, illegal;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    dual_core_boot_seq #(.STOP_SETTLE(SETTLE)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .p_sleep_req (stim[10]),
        .p_stop_req  (stim[9]),
        .s_sleep_req (stim[8]),
        .s_stop_req  (stim[7]),
        .p_wake      (stim[6]),
        .s_wake      (stim[5]),
        .boot_set    (stim[4]),
        .boot_clr    (stim[3]),
        .stby_req    (stim[2]),
        .s_access    (stim[1]),
        .ill_clr     (stim[0]),
        .p_clk_en    (p_clk_en),
        .p_run_en    (p_run_en),
        .s_clk_en    (s_clk_en),
        .s_run_en    (s_run_en),
        .sys_mode    (sys_mode),
        .boot_flag   (boot_flag),
        .boot_status (boot_status),
        .illegal     (illegal)
    );

    function automatic logic [8:0] observed();
        return {p_clk_en, p_run_en, s_clk_en, s_run_en, sys_mode,
                boot_flag, boot_status, illegal};
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [10:0] v, input int idle);
        @(negedge clk);
        stim = v;
        @(negedge clk);
        stim = v & 11'b00000000100;
        for (int k = 0; k < idle; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", observed(), 9'b1100_00_000);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][23:13], int'(VEC[i][12:9]));
            check($sformatf("vector %0d (R2..R10)", i), observed(), VEC[i][8:0]);
        end

        // R7 settle boundary: primary stops, secondary held
        @(negedge clk);
        stim = 11'b01000000000;
        @(negedge clk);
        stim = '0;
        repeat (SETTLE) @(negedge clk);
        check("R7 mode still Run one edge before settle ends", observed(), 9'b0000_00_000);
        @(negedge clk);
        check("R7 mode Stop at settle end", observed(), 9'b0000_01_000);

        // R8 primary wake
        apply(11'b00001000000, 0);
        check("R8 wake from Stop", observed(), 9'b1100_00_000);

        // R9 access and clear in the same cycle
        apply(11'b00000000011, 0);
        check("R9 set wins over clear", observed(), 9'b1100_00_001);
        apply(11'b00000000001, 0);
        check("R9 cleared", observed(), 9'b1100_00_000);

        // R10 set and clear together; R2 no release without pending wake after first boot
        apply(11'b00000011000, 2);
        check("R10 R2 set wins, held without pending wake", observed(), 9'b1100_00_100);

        // R2 wake now releases
        apply(11'b00000100000, 1);
        check("R2 release on wake with flag", observed(), 9'b1111_00_110);

        // R1 reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset after activity", observed(), 9'b1100_00_000);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule